// File: doc/BRIEF.md
# Dual-Processor Sync Mailbox Register

This block joins two processors, called side A and side B, through a pair of mirrored 32-bit sync registers. Each side has its own bus port with a select, a write flag, a byte address, four byte-lane strobes, write data and read data. Each side owns one outgoing byte that it writes and reads back. It also reads the byte that the other side last wrote. The two register views are cross-wired: side A's outgoing byte appears as side B's incoming byte, and the other way round.

Either side can request a sync interrupt on either processor by writing a one to a self-clearing trigger bit. A request is delivered as a one-clock pulse on the target's interrupt output. It is delivered only when the target processor's own enable bit is set; otherwise it is dropped and not latched. Both ports share one clock and one active-low asynchronous reset. Only the sync word at offset 0x0 is live. Offsets 0x8 and 0xC, which belong to queue ports outside this block, read as zero and ignore writes.

Top module: `sync_mailbox`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both outgoing bytes and both enable bits are zero and both interrupt outputs are low.
- R2: A write to offset 0x0 with lane strobe 1 set stores wdata[15:8] as that side's outgoing byte, and a later read returns it in rdata[15:8].
- R3: rdata[7:0] of a read at offset 0x0 returns the other side's outgoing byte, and writes to lane 0 change nothing.
- R4: Bit 31 is the side's interrupt enable. A write with lane strobe 3 set stores wdata[31], and reads return it.
- R5: A write with lane 3 set and wdata[30]=1, from either side, raises irq_a for exactly the next cycle only if A's enable was already set before that write. Otherwise the request is dropped.
- R6: A write with lane 3 set and wdata[29]=1, from either side, raises irq_b for exactly the next cycle only if B's enable was already set before that write. Otherwise the request is dropped.
- R7: Bits 30 down to 16 always read as 0, which covers both trigger bits and bit 23.
- R8: A write updates only the lanes whose strobe is set. Lanes whose strobe is clear keep their stored value.
- R9: Accesses at any offset other than 0x0, such as 0x8 and 0xC, read as zero and change no state.
- R10: Triggers written in the same cycle by both sides are all delivered. Two requests aimed at the same target in one cycle give a single pulse.
- R11: A read that happens in the same cycle as the other side's write to its outgoing byte returns the value from before the write.
- R12: rdata is zero whenever the port is not performing a read (select low, or write high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel | input | 1 | Side A access select |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_addr | input | ADDR_W | Side A byte offset |
| a_be | input | 4 | Side A byte-lane strobes |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| b_sel | input | 1 | Side B access select |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_addr | input | ADDR_W | Side B byte offset |
| b_be | input | 4 | Side B byte-lane strobes |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| irq_a | output | 1 | One-cycle sync interrupt to processor A |
| irq_b | output | 1 | One-cycle sync interrupt to processor B |

## Verification
Directed sequences come first. Each side writes distinct byte values, which separates a correct cross-wiring from a loop-back or swapped view. Triggers are written with the target enable set, clear, and set by the same write, which shows whether gating uses the enable value from before the write. Single-lane and mixed-lane strobes, and accesses at 0x8 and 0xC, show up any lane or decode leakage. Simultaneous triggers and a read in the same cycle as a peer write cover the concurrency rules. A long pseudo-random run on both ports then compares every output on every clock against a behavioural model.

// File: rtl/sync_mbx_pkg.sv
package sync_mbx_pkg;
  localparam int WORD_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int LANES     = WORD_W / BYTE_W;
  localparam int SIDES     = 2;
  localparam int OWN_LANE  = 1;
  localparam int CTRL_LANE = 3;
  localparam int BIT_EN    = 31;
  localparam int BIT_TRG_A = 30;
  localparam int BIT_TRG_B = 29;

  typedef struct packed {
    logic to_b;
    logic to_a;
  } trig_t;

  // Assemble the read view of one side: enable, zeros, own byte, peer byte.
  function automatic logic [WORD_W-1:0] pack_view(input logic en,
                                                  input logic [BYTE_W-1:0] own,
                                                  input logic [BYTE_W-1:0] peer);
    logic [WORD_W-1:0] v;
    v = '0;
    v[BIT_EN] = en;
    v[OWN_LANE*BYTE_W +: BYTE_W] = own;
    v[BYTE_W-1:0] = peer;
    return v;
  endfunction

  // Take the new byte only when its lane strobe is set.
  function automatic logic [BYTE_W-1:0] lane_merge(input logic [BYTE_W-1:0] old_b,
                                                   input logic [BYTE_W-1:0] new_b,
                                                   input logic strobe);
    return strobe ? new_b : old_b;
  endfunction
endpackage

// File: rtl/sync_mbx_port.sv
module sync_mbx_port
  import sync_mbx_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int SYNC_OFS = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [LANES-1:0]     be,
  input  logic [WORD_W-1:0]    wdata,
  input  logic [BYTE_W-1:0]    peer_byte,
  output logic [WORD_W-1:0]    rdata,
  output logic [BYTE_W-1:0]    own_byte,
  output logic                 irq_en,
  output trig_t                trig
);
  localparam logic [ADDR_W-1:0] SYNC_ADDR = ADDR_W'(SYNC_OFS);

  logic hit, wr_acc, rd_acc, ctrl_wr;

  assign hit     = (addr == SYNC_ADDR);
  assign wr_acc  = sel & we & hit;
  assign rd_acc  = sel & ~we & hit;
  assign ctrl_wr = wr_acc & be[CTRL_LANE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_byte <= '0;
      irq_en   <= 1'b0;
    end else if (wr_acc) begin
      own_byte <= lane_merge(own_byte, wdata[OWN_LANE*BYTE_W +: BYTE_W], be[OWN_LANE]);
      if (be[CTRL_LANE]) irq_en <= wdata[BIT_EN];
    end
  end

  always_comb begin
    trig.to_a = ctrl_wr & wdata[BIT_TRG_A];
    trig.to_b = ctrl_wr & wdata[BIT_TRG_B];
  end

  assign rdata = rd_acc ? pack_view(irq_en, own_byte, peer_byte) : '0;
endmodule

// File: rtl/sync_mbx_irq.sv
module sync_mbx_irq
  import sync_mbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  trig_t            trig_from_a,
  input  trig_t            trig_from_b,
  input  logic [SIDES-1:0] en,
  output logic [SIDES-1:0] req,
  output logic [SIDES-1:0] deliver,
  output logic [SIDES-1:0] irq
);
  assign req[0] = trig_from_a.to_a | trig_from_b.to_a;
  assign req[1] = trig_from_a.to_b | trig_from_b.to_b;

  for (genvar t = 0; t < SIDES; t++) begin : g_tgt
    assign deliver[t] = req[t] & en[t];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq[t] <= 1'b0;
      else        irq[t] <= deliver[t];
    end
  end
endmodule

// File: rtl/sync_mailbox.sv
module sync_mailbox
  import sync_mbx_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int SYNC_OFS = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_sel,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [3:0]        a_be,
  input  logic [31:0]       a_wdata,
  output logic [31:0]       a_rdata,
  input  logic              b_sel,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [3:0]        b_be,
  input  logic [31:0]       b_wdata,
  output logic [31:0]       b_rdata,
  output logic              irq_a,
  output logic              irq_b
);
  logic              p_sel   [SIDES];
  logic              p_we    [SIDES];
  logic [ADDR_W-1:0] p_addr  [SIDES];
  logic [LANES-1:0]  p_be    [SIDES];
  logic [WORD_W-1:0] p_wdata [SIDES];
  logic [WORD_W-1:0] p_rdata [SIDES];
  logic [BYTE_W-1:0] own_byte[SIDES];
  trig_t             trig    [SIDES];
  logic [SIDES-1:0]  irq_en;
  logic [SIDES-1:0]  irq_req;
  logic [SIDES-1:0]  irq_deliver;
  logic [SIDES-1:0]  irq_vec;

  // Named views for the checker
  logic [BYTE_W-1:0] own_a, own_b;
  logic              en_a, en_b, req_a, req_b;

  assign p_sel[0] = a_sel;   assign p_sel[1] = b_sel;
  assign p_we[0]  = a_we;    assign p_we[1]  = b_we;
  assign p_addr[0] = a_addr; assign p_addr[1] = b_addr;
  assign p_be[0]  = a_be;    assign p_be[1]  = b_be;
  assign p_wdata[0] = a_wdata; assign p_wdata[1] = b_wdata;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    sync_mbx_port #(.ADDR_W(ADDR_W), .SYNC_OFS(SYNC_OFS)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (p_sel[s]),
      .we       (p_we[s]),
      .addr     (p_addr[s]),
      .be       (p_be[s]),
      .wdata    (p_wdata[s]),
      .peer_byte(own_byte[SIDES-1-s]),
      .rdata    (p_rdata[s]),
      .own_byte (own_byte[s]),
      .irq_en   (irq_en[s]),
      .trig     (trig[s])
    );
  end

  sync_mbx_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_from_a(trig[0]),
    .trig_from_b(trig[1]),
    .en         (irq_en),
    .req        (irq_req),
    .deliver    (irq_deliver),
    .irq        (irq_vec)
  );

  assign a_rdata = p_rdata[0];
  assign b_rdata = p_rdata[1];
  assign irq_a   = irq_vec[0];
  assign irq_b   = irq_vec[1];
  assign own_a   = own_byte[0];
  assign own_b   = own_byte[1];
  assign en_a    = irq_en[0];
  assign en_b    = irq_en[1];
  assign req_a   = irq_req[0];
  assign req_b   = irq_req[1];
endmodule

// File: rtl/sync_mailbox_chk.sv
module sync_mailbox_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_sel,
  input logic              a_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic [3:0]        a_be,
  input logic [31:0]       a_wdata,
  input logic [31:0]       a_rdata,
  input logic              b_sel,
  input logic              b_we,
  input logic [ADDR_W-1:0] b_addr,
  input logic [31:0]       b_rdata,
  input logic              irq_a,
  input logic              irq_b,
  input logic [7:0]        own_a,
  input logic [7:0]        own_b,
  input logic              en_a,
  input logic              en_b,
  input logic              req_a,
  input logic              req_b
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq_a && !irq_b && own_a == 8'h00 && own_b == 8'h00 && !en_a && !en_b));

  assert_own_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sel && a_we && a_addr == '0 && a_be[1]) |=> own_a == $past(a_wdata[15:8]));

  assert_peer_view_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_sel && !b_we && b_addr == '0) |-> b_rdata[7:0] == own_a);

  assert_irq_a_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> ($past(en_a) && $past(req_a)));

  assert_irq_b_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b |-> ($past(en_b) && $past(req_b)));

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rdata[30:16] == '0) && (b_rdata[30:16] == '0));

  assert_lane_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_sel && a_we && a_addr == '0 && a_be[1]) |=> $stable(own_a));

  assert_other_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_addr != '0) |-> a_rdata == '0);

  assert_both_delivered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_a && en_a && req_b && en_b) |=> (irq_a && irq_b));

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_sel && !a_we) |-> a_rdata == '0);
endmodule

bind sync_mailbox sync_mailbox_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_sel(a_sel), .a_we(a_we), .a_addr(a_addr), .a_be(a_be), .a_wdata(a_wdata), .a_rdata(a_rdata),
  .b_sel(b_sel), .b_we(b_we), .b_addr(b_addr), .b_rdata(b_rdata),
  .irq_a(irq_a), .irq_b(irq_b), .own_a(own_a), .own_b(own_b),
  .en_a(en_a), .en_b(en_b), .req_a(req_a), .req_b(req_b)
);

// File: tb/sync_mailbox_tb.sv
`timescale 1ns/1ps
module sync_mailbox_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_sel = 0, a_we = 0, b_sel = 0, b_we = 0;
  logic [3:0] a_addr = 0, a_be = 0, b_addr = 0, b_be = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic irq_a, irq_b;

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  sync_mailbox u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_we(a_we), .a_addr(a_addr), .a_be(a_be), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_sel(b_sel), .b_we(b_we), .b_addr(b_addr), .b_be(b_be), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  // Behavioural reference model, side 0 = A, side 1 = B
  int m_out[2];
  int m_en[2];
  int m_irq[2];

  function automatic bit is_wr(input logic s, input logic w, input logic [3:0] ad);
    return s && w && ad == 4'h0;
  endfunction

  function automatic logic [31:0] expect_rd(input int side, input logic s, input logic w,
                                            input logic [3:0] ad);
    logic [31:0] r;
    r = 32'h0;
    if (s && !w && ad == 4'h0) begin
      r = m_out[side] * 256 + m_out[1 - side];
      if (m_en[side] != 0) r = r + 32'h8000_0000;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin m_out[i] = 0; m_en[i] = 0; m_irq[i] = 0; end
    end else begin
      bit ta, tb;
      ta = (is_wr(a_sel, a_we, a_addr) && a_be[3] && a_wdata[30]) ||
           (is_wr(b_sel, b_we, b_addr) && b_be[3] && b_wdata[30]);
      tb = (is_wr(a_sel, a_we, a_addr) && a_be[3] && a_wdata[29]) ||
           (is_wr(b_sel, b_we, b_addr) && b_be[3] && b_wdata[29]);
      m_irq[0] = (ta && m_en[0] != 0) ? 1 : 0;
      m_irq[1] = (tb && m_en[1] != 0) ? 1 : 0;
      if (is_wr(a_sel, a_we, a_addr)) begin
        if (a_be[1]) m_out[0] = int'(a_wdata[15:8]);
        if (a_be[3]) m_en[0] = int'(a_wdata[31]);
      end
      if (is_wr(b_sel, b_we, b_addr)) begin
        if (b_be[1]) m_out[1] = int'(b_wdata[15:8]);
        if (b_be[3]) m_en[1] = int'(b_wdata[31]);
      end
    end
  end

  task automatic check32(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // Compare every output against the model away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check32("a_rdata", a_rdata, expect_rd(0, a_sel, a_we, a_addr));
      check32("b_rdata", b_rdata, expect_rd(1, b_sel, b_we, b_addr));
      check32("irq_a", {31'h0, irq_a}, m_irq[0]);
      check32("irq_b", {31'h0, irq_b}, m_irq[1]);
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic port(input int side, input logic s, input logic w, input logic [3:0] ad,
                      input logic [3:0] bee, input logic [31:0] d);
    if (side == 0) begin a_sel = s; a_we = w; a_addr = ad; a_be = bee; a_wdata = d; end
    else           begin b_sel = s; b_we = w; b_addr = ad; b_be = bee; b_wdata = d; end
  endtask

  task automatic idle();
    port(0, 0, 0, 4'h0, 4'h0, 32'h0);
    port(1, 0, 0, 4'h0, 4'h0, 32'h0);
  endtask

  task automatic rd_both();
    port(0, 1, 0, 4'h0, 4'h0, 32'h0);
    port(1, 1, 0, 4'h0, 4'h0, 32'h0);
    tick();
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    // R1: reset state, including a read while in reset
    cur_req = "R1";
    port(0, 1, 0, 4'h0, 4'h0, 32'h0);
    tick(); tick();
    rst_n = 1'b1;
    tick(); rd_both(); idle();

    // R2 / R3: distinct bytes each way show the cross-wiring
    cur_req = "R2";
    port(0, 1, 1, 4'h0, 4'b0010, 32'h0000_5A00); tick(); idle(); rd_both();
    cur_req = "R3";
    port(1, 1, 1, 4'h0, 4'b0011, 32'h0000_C3FF); tick(); rd_both();

    // R8: lane independence, lane 1 clear leaves byte, lane 3 only
    cur_req = "R8";
    port(0, 1, 1, 4'h0, 4'b1101, 32'h8000_77FF); tick(); rd_both();
    port(0, 1, 1, 4'h0, 4'b0000, 32'hFFFF_FFFF); tick(); rd_both();

    // R4: enable on B, then clear A
    cur_req = "R4";
    port(1, 1, 1, 4'h0, 4'b1000, 32'h8000_0000); tick(); rd_both();
    port(0, 1, 1, 4'h0, 4'b1000, 32'h0000_0000); tick(); rd_both();

    // R5: A disabled drops the request; enable and trigger together also drops
    cur_req = "R5";
    port(1, 1, 1, 4'h0, 4'b1000, 32'hC000_0000); tick(); idle(); tick(); tick();
    port(0, 1, 1, 4'h0, 4'b1000, 32'hC000_0000); tick(); idle(); tick(); tick();
    port(1, 1, 1, 4'h0, 4'b1000, 32'hC000_0000); tick(); idle(); tick(); tick();
    // R6: B enabled, trigger from A
    cur_req = "R6";
    port(0, 1, 1, 4'h0, 4'b1000, 32'hA000_0000); tick(); idle(); tick(); tick();
    port(0, 1, 1, 4'h0, 4'b0111, 32'h2000_0000); tick(); idle(); tick();

    // R7: triggers and reserved bits read back zero
    cur_req = "R7";
    port(0, 1, 1, 4'h0, 4'b1111, 32'hFFFF_12AB); tick(); rd_both();

    // R9: other offsets
    cur_req = "R9";
    port(0, 1, 1, 4'h8, 4'b1111, 32'h6000_EE00); port(1, 1, 0, 4'hC, 4'h0, 32'h0); tick();
    port(0, 1, 0, 4'h8, 4'h0, 32'h0); port(1, 1, 1, 4'hC, 4'b1111, 32'h6000_DD00); tick();
    rd_both();

    // R10: both sides trigger in one cycle, both targets, and same target twice
    cur_req = "R10";
    port(0, 1, 1, 4'h0, 4'b1000, 32'hE000_0000); port(1, 1, 1, 4'h0, 4'b1000, 32'hE000_0000);
    tick(); idle(); tick();
    port(0, 1, 1, 4'h0, 4'b1000, 32'hC000_0000); port(1, 1, 1, 4'h0, 4'b1000, 32'hA000_0000);
    tick(); idle(); tick();
    port(0, 1, 1, 4'h0, 4'b1000, 32'hC000_0000); port(1, 1, 1, 4'h0, 4'b1000, 32'hC000_0000);
    tick(); idle(); tick();

    // R11: read in the same cycle the peer writes
    cur_req = "R11";
    port(0, 1, 1, 4'h0, 4'b0010, 32'h0000_3C00); port(1, 1, 0, 4'h0, 4'h0, 32'h0); tick();
    idle(); rd_both();

    // R12: write cycles and unselected cycles give zero read data
    cur_req = "R12";
    port(0, 1, 1, 4'h0, 4'b0000, 32'h0); port(1, 0, 0, 4'h0, 4'h0, 32'h0); tick();
    idle(); tick();

    // Mixed pseudo-random traffic against the model (R2, R3, R5, R6, R8, R10)
    cur_req = "R10";
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      port(0, lfsr[0], lfsr[1], {lfsr[3:2] & {2{lfsr[4]}}, 2'b00}, lfsr[8:5], lfsr ^ 32'h5A5A_0000);
      port(1, lfsr[9], lfsr[10], {lfsr[12:11] & {2{lfsr[13]}}, 2'b00}, lfsr[17:14],
           {lfsr[15:0], lfsr[31:16]});
      tick();
    end
    idle(); tick(); tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule